// File: doc/BRIEF.md
# Calendar Alarm Matcher with Wake Control

This block holds seven programmable alarm bytes (seconds, minutes, hours, day of week, date, month, year) and compares them with the current calendar on every once-per-second evaluation strobe. Any alarm byte can be a wildcard, and a wildcard matches every value of its field. The wildcard code is any byte whose two top bits are both 1, which covers 0xC0 to 0xFF. Mixing wildcards and exact bytes gives a yearly, monthly, daily, hourly, per-minute, per-second or weekly alarm. A match produces a one-cycle pulse and sets a sticky alarm flag.

The block also drives an active-low power-on request. When standby power is present, a match pulls the request low only if the local wake enable is set. When standby power is absent, a match with the remote-wake enable set is held in a pending latch. The request then goes low as soon as standby power returns, whatever the local wake enable says. A control-register write releases the request or clears the flag. Time counting and BCD/binary conversion stay outside the block.

Top module: `cal_alarm_wake`

## Requirements
- R1: After reset, match_pulse_o and alarm_flag_o are 0, pwr_on_n_o is 1, every alarm byte holds 0x00 and both enables are 0.
- R2: An alarm byte whose bits [7:6] are both 1 is a wildcard and matches any time byte. All seven bytes as wildcards match on every strobe. Year, month and date as wildcards with an exact day of week match only on that weekday.
- R3: Matching is evaluated only when tick_i is 1. match_pulse_o is 1 for exactly the cycle after a strobe cycle in which every field matched, and is 0 otherwise.
- R4: A byte with bits [7:6] not both 1 (0xBF included) matches only an equal time byte. A mismatch in any single such field gives no pulse.
- R5: alarm_flag_o sets in the same cycle as match_pulse_o and stays 1 until a write to address 7 with bit 3 set. If that write coincides with a matching strobe, the flag stays 1.
- R6: While standby_ok_i is 1, a matching strobe drives pwr_on_n_o low in the next cycle if wake enable (address 7 bit 0) is 1. If wake enable is 0, the strobe leaves pwr_on_n_o unchanged.
- R7: While standby_ok_i is 0, a matching strobe with remote enable (address 7 bit 1) set leaves pwr_on_n_o high and records a pending wake. pwr_on_n_o goes low in the cycle after standby_ok_i returns to 1, independent of wake enable.
- R8: A matching strobe while standby_ok_i is 0 with remote enable 0 causes no wake on power return, even with wake enable set.
- R9: pwr_on_n_o stays low until a write to address 7 with bit 2 set. That write also discards a pending wake. A wake set in the same cycle as such a write wins.
- R10: Write addresses 0..6 load the alarm byte for seconds, minutes, hours, day of week, date, month and year. now_i carries the matching time byte i at bits [8i+7:8i]. An alarm byte written in the same cycle as a strobe takes effect from the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Once-per-second evaluation strobe |
| now_i | input | 56 | Current time bytes, byte i at bits [8i+7:8i] (0 = seconds … 6 = year) |
| standby_ok_i | input | 1 | Standby power present |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0..6 alarm bytes, 7 control |
| wr_data_i | input | 8 | Write data (control: bit0 wake enable, bit1 remote enable, bit2 release request, bit3 clear flag) |
| match_pulse_o | output | 1 | One-cycle alarm match pulse |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| pwr_on_n_o | output | 1 | Active-low power-on request |

## Verification
The hardest situation to reach is a wake that must survive an outage. A match has to land while standby power is absent, with only the remote enable set. Power then returns and the request must fall while the local enable is still 0. The bench builds this by dropping standby power before a matching strobe and holding it down for several cycles before restoring it. It repeats the sequence with the release write issued during the outage, and with only the local enable set. Coincident events (a clear with a match, a release with a wake) are driven in the same cycle on purpose. A random phase mixes strobes, writes and power toggles near the 0xBF/0xC0 wildcard boundary.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
   // field order on now_i and on the alarm write addresses
   localparam int unsigned FLD_SEC   = 0;
   localparam int unsigned FLD_MIN   = 1;
   localparam int unsigned FLD_HOUR  = 2;
   localparam int unsigned FLD_WDAY  = 3;
   localparam int unsigned FLD_DATE  = 4;
   localparam int unsigned FLD_MONTH = 5;
   localparam int unsigned FLD_YEAR  = 6;
   localparam int unsigned CAL_FIELDS = 7;

   // control word bit positions
   localparam int unsigned CTL_WAKE_EN   = 0;
   localparam int unsigned CTL_REMOTE_EN = 1;
   localparam int unsigned CTL_CLR_WAKE  = 2;
   localparam int unsigned CTL_CLR_FLAG  = 3;
   localparam int unsigned CTL_MIN_W     = 4;

   typedef struct packed {
      logic remote_en;
      logic wake_en;
   } wake_cfg_t;
endpackage

// File: rtl/cal_alarm_field_cmp.sv
module cal_alarm_field_cmp #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned WILD_BITS   = 2,
   parameter bit          WILDCARD_EN = 1'b1
) (
   input  logic [BYTE_W-1:0] alarm_b_i,
   input  logic [BYTE_W-1:0] time_b_i,
   output logic              hit_o,
   output logic              wild_o
);
   generate
      if (WILDCARD_EN) begin : g_wild
         assign wild_o = &alarm_b_i[BYTE_W-1 -: WILD_BITS];
      end else begin : g_exact
         assign wild_o = 1'b0;
      end
   endgenerate

   assign hit_o = wild_o | (alarm_b_i == time_b_i);
endmodule

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
   import cal_alarm_pkg::*;
#(
   parameter int unsigned NUM_FIELDS = 7,
   parameter int unsigned BYTE_W     = 8,
   parameter int unsigned ADDR_W     = 3,
   parameter logic [7:0]  RST_BYTE   = 8'h00
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en_i,
   input  logic [ADDR_W-1:0]            wr_addr_i,
   input  logic [BYTE_W-1:0]            wr_data_i,
   output logic [NUM_FIELDS*BYTE_W-1:0] alarm_bytes_o,
   output wake_cfg_t                    cfg_o,
   output logic                         clr_wake_o,
   output logic                         clr_flag_o
);
   localparam int unsigned CTRL_ADDR = NUM_FIELDS;

   logic ctrl_sel;
   assign ctrl_sel = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));

   generate
      for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               alarm_bytes_o[gi*BYTE_W +: BYTE_W] <= BYTE_W'(RST_BYTE);
            end else if (wr_en_i && (wr_addr_i == ADDR_W'(gi))) begin
               alarm_bytes_o[gi*BYTE_W +: BYTE_W] <= wr_data_i;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_o <= '0;
      end else if (ctrl_sel) begin
         cfg_o.wake_en   <= wr_data_i[CTL_WAKE_EN];
         cfg_o.remote_en <= wr_data_i[CTL_REMOTE_EN];
      end
   end

   assign clr_wake_o = ctrl_sel && wr_data_i[CTL_CLR_WAKE];
   assign clr_flag_o = ctrl_sel && wr_data_i[CTL_CLR_FLAG];

   // R10
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_sel |=> (cfg_o.wake_en == $past(wr_data_i[CTL_WAKE_EN])));
endmodule

// File: rtl/cal_alarm_wake_ctl.sv
module cal_alarm_wake_ctl
   import cal_alarm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      hit_tick_i,
   input  logic      standby_ok_i,
   input  wake_cfg_t cfg_i,
   input  logic      clr_wake_i,
   output logic      pwr_on_n_o
);
   logic req_q, req_d;
   logic pend_q, pend_d;
   logic wake_now, pend_set, pend_release;

   assign pend_release = pend_q && standby_ok_i;
   assign wake_now     = (hit_tick_i && standby_ok_i && cfg_i.wake_en) || pend_release;
   assign pend_set     = hit_tick_i && !standby_ok_i && cfg_i.remote_en;

   always_comb begin
      req_d = req_q;
      if (clr_wake_i) req_d = 1'b0;
      if (wake_now)   req_d = 1'b1;
      pend_d = pend_q;
      if (clr_wake_i)   pend_d = 1'b0;
      if (pend_release) pend_d = 1'b0;
      if (pend_set)     pend_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         req_q  <= req_d;
         pend_q <= pend_d;
      end
   end

   assign pwr_on_n_o = ~req_q;

   // R7
   pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && standby_ok_i) |=> !pwr_on_n_o);
   // R7
   no_wake_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_on_n_o) |-> $past(standby_ok_i));
   // R8
   pend_needs_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(cfg_i.remote_en && !standby_ok_i && hit_tick_i));
   // R9
   wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_on_n_o) |-> $past(clr_wake_i));
endmodule

// File: rtl/cal_alarm_wake.sv
module cal_alarm_wake
   import cal_alarm_pkg::*;
#(
   parameter int unsigned NUM_FIELDS  = CAL_FIELDS,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned WILD_BITS   = 2,
   parameter bit          WILDCARD_EN = 1'b1,
   parameter logic [7:0]  RST_BYTE    = 8'h00,
   localparam int unsigned ADDR_W     = $clog2(NUM_FIELDS + 1),
   localparam int unsigned TIME_W     = NUM_FIELDS * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [TIME_W-1:0] now_i,
   input  logic              standby_ok_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   output logic              match_pulse_o,
   output logic              alarm_flag_o,
   output logic              pwr_on_n_o
);
   generate
      if (WILD_BITS < 1 || WILD_BITS > BYTE_W) begin : g_bad_wild
         $error("WILD_BITS must lie in 1..BYTE_W");
      end
      if (BYTE_W < CTL_MIN_W) begin : g_bad_width
         $error("BYTE_W too narrow for the control word");
      end
      if (NUM_FIELDS < 1) begin : g_bad_fields
         $error("NUM_FIELDS must be at least 1");
      end
   endgenerate

   logic [TIME_W-1:0]     alarm_bytes;
   logic [NUM_FIELDS-1:0] field_hit, field_wild;
   logic                  all_hit, hit_tick;
   logic                  clr_wake, clr_flag;
   wake_cfg_t             cfg;

   cal_alarm_regs #(
      .NUM_FIELDS (NUM_FIELDS),
      .BYTE_W     (BYTE_W),
      .ADDR_W     (ADDR_W),
      .RST_BYTE   (RST_BYTE)
   ) regs_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en_i       (wr_en_i),
      .wr_addr_i     (wr_addr_i),
      .wr_data_i     (wr_data_i),
      .alarm_bytes_o (alarm_bytes),
      .cfg_o         (cfg),
      .clr_wake_o    (clr_wake),
      .clr_flag_o    (clr_flag)
   );

   generate
      for (genvar gf = 0; gf < NUM_FIELDS; gf++) begin : g_field
         cal_alarm_field_cmp #(
            .BYTE_W      (BYTE_W),
            .WILD_BITS   (WILD_BITS),
            .WILDCARD_EN (WILDCARD_EN)
         ) cmp_i (
            .alarm_b_i (alarm_bytes[gf*BYTE_W +: BYTE_W]),
            .time_b_i  (now_i[gf*BYTE_W +: BYTE_W]),
            .hit_o     (field_hit[gf]),
            .wild_o    (field_wild[gf])
         );
      end
   endgenerate

   assign all_hit  = &field_hit;
   assign hit_tick = tick_i && all_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_pulse_o <= 1'b0;
         alarm_flag_o  <= 1'b0;
      end else begin
         match_pulse_o <= hit_tick;
         if (hit_tick)      alarm_flag_o <= 1'b1;
         else if (clr_flag) alarm_flag_o <= 1'b0;
      end
   end

   cal_alarm_wake_ctl wake_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .hit_tick_i   (hit_tick),
      .standby_ok_i (standby_ok_i),
      .cfg_i        (cfg),
      .clr_wake_i   (clr_wake),
      .pwr_on_n_o   (pwr_on_n_o)
   );

   // R3
   pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pulse_o |-> $past(tick_i));
   // R2
   all_wild_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && (&field_wild)) |=> match_pulse_o);
   // R5
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag_o) |-> match_pulse_o);
   // R5
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alarm_flag_o) |-> $past(clr_flag));
   // R6
   local_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_tick && standby_ok_i && cfg.wake_en) |=> !pwr_on_n_o);
endmodule

// File: tb/cal_alarm_wake_tb_top.sv
`timescale 1ns/1ps
module cal_alarm_wake_tb_top;
   localparam int NF = 7;
   localparam int BW = 8;
   localparam int AW = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [NF*BW-1:0] now_flat;
   logic          standby = 1'b1;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [BW-1:0] wr_data = '0;
   logic          pulse, flag, pwr_n;

   logic [7:0] now_b [NF];

   always_comb begin
      for (int i = 0; i < NF; i++) now_flat[i*BW +: BW] = now_b[i];
   end

   cal_alarm_wake dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick_i        (tick),
      .now_i         (now_flat),
      .standby_ok_i  (standby),
      .wr_en_i       (wr_en),
      .wr_addr_i     (wr_addr),
      .wr_data_i     (wr_data),
      .match_pulse_o (pulse),
      .alarm_flag_o  (flag),
      .pwr_on_n_o    (pwr_n)
   );

   // behavioural reference
   logic [7:0] m_al [NF];
   bit m_wen, m_ren, m_flag, m_req, m_pend, m_pulse;
   int checks = 0;
   int fails = 0;
   bit running = 0;
   string tag = "R1";

   function automatic bit ref_match();
      for (int i = 0; i < NF; i++)
         if (!(m_al[i][7:6] == 2'b11 || m_al[i] == now_b[i])) return 1'b0;
      return 1'b1;
   endfunction

   always @(posedge clk) begin : model
      bit hit, clrw, clrf, nreq, npend, nflag;
      if (!rst_n) begin
         for (int i = 0; i < NF; i++) m_al[i] = 8'h00;
         m_wen = 0; m_ren = 0; m_flag = 0; m_req = 0; m_pend = 0; m_pulse = 0;
      end else begin
         hit  = tick && ref_match();
         clrw = wr_en && wr_addr == 3'd7 && wr_data[2];
         clrf = wr_en && wr_addr == 3'd7 && wr_data[3];
         nreq = m_req;
         if (clrw) nreq = 0;
         if ((hit && standby && m_wen) || (m_pend && standby)) nreq = 1;
         npend = m_pend;
         if (clrw) npend = 0;
         if (m_pend && standby) npend = 0;
         if (hit && !standby && m_ren) npend = 1;
         nflag = m_flag;
         if (clrf) nflag = 0;
         if (hit) nflag = 1;
         if (wr_en) begin
            if (wr_addr < 3'd7) m_al[wr_addr] = wr_data;
            else begin m_wen = wr_data[0]; m_ren = wr_data[1]; end
         end
         m_req = nreq; m_pend = npend; m_flag = nflag; m_pulse = hit;
      end
      running = 1;
   end

   always @(negedge clk) begin
      if (running) begin
         checks++;
         if (pulse !== m_pulse || flag !== m_flag || pwr_n !== !m_req) begin
            fails++;
            $display("FAIL %s: pulse,flag,pwr_n actual %b%b%b expected %b%b%b",
                     tag, pulse, flag, pwr_n, m_pulse, m_flag, !m_req);
         end
      end
   end

   task automatic chk(input logic act, input logic exp, input string t);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", t, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic set_now(input logic [7:0] y, mo, dt, wd, h, mi, s);
      now_b[6] = y; now_b[5] = mo; now_b[4] = dt; now_b[3] = wd;
      now_b[2] = h; now_b[1] = mi; now_b[0] = s;
   endtask

   task automatic tk(input logic [7:0] y, mo, dt, wd, h, mi, s);
      @(negedge clk); set_now(y, mo, dt, wd, h, mi, s); tick = 1;
      @(negedge clk); tick = 0;
   endtask

   task automatic fin();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      fin();
   end

   initial begin
      set_now(0, 0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(pulse, 1'b0, "R1 pulse"); chk(flag, 1'b0, "R1 flag"); chk(pwr_n, 1'b1, "R1 pwr");
      // reset bytes are 0x00: an all-zero time matches
      tk(0, 0, 0, 0, 0, 0, 0);
      chk(pulse, 1'b1, "R1 reset bytes");

      tag = "R2";
      wr(0, 8'hC0); wr(1, 8'hC5); wr(2, 8'hD3); wr(3, 8'hE0);
      wr(4, 8'hF1); wr(5, 8'hFE); wr(6, 8'hFF);
      tk(8'h24, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
      chk(pulse, 1'b1, "R2 all wild");
      tk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07);
      wr(0, 8'h30);
      tk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h30);
      tk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h31);
      chk(pulse, 1'b0, "R4 seconds mismatch");

      tag = "R2";  // weekly
      wr(6, 8'hFF); wr(5, 8'hC0); wr(4, 8'hE7); wr(3, 8'h05);
      wr(2, 8'h08); wr(1, 8'h00); wr(0, 8'h00);
      tk(8'h24, 8'h03, 8'h15, 8'h05, 8'h08, 8'h00, 8'h00);
      chk(pulse, 1'b1, "R2 weekday hit");
      tk(8'h25, 8'h07, 8'h02, 8'h05, 8'h08, 8'h00, 8'h00);
      tk(8'h24, 8'h03, 8'h16, 8'h03, 8'h08, 8'h00, 8'h00);
      chk(pulse, 1'b0, "R2 other weekday");

      tag = "R4";
      wr(0, 8'h15); wr(1, 8'h42); wr(2, 8'h07); wr(3, 8'h03);
      wr(4, 8'h19); wr(5, 8'h06); wr(6, 8'h24);
      tk(8'h24, 8'h06, 8'h19, 8'h03, 8'h07, 8'h42, 8'h15);
      for (int i = 0; i < NF; i++) begin
         @(negedge clk);
         set_now(8'h24, 8'h06, 8'h19, 8'h03, 8'h07, 8'h42, 8'h15);
         now_b[i] = now_b[i] + 8'd1; tick = 1;
         @(negedge clk); tick = 0;
         chk(pulse, 1'b0, "R4 single field off");
      end
      wr(6, 8'hBF);
      tk(8'h24, 8'h06, 8'h19, 8'h03, 8'h07, 8'h42, 8'h15);
      chk(pulse, 1'b0, "R4 0xBF not wild");
      tk(8'hBF, 8'h06, 8'h19, 8'h03, 8'h07, 8'h42, 8'h15);
      chk(pulse, 1'b1, "R4 0xBF exact");

      tag = "R10";  // byte written alongside a strobe takes effect later
      @(negedge clk); wr_en = 1; wr_addr = 3'd0; wr_data = 8'h16; tick = 1;
      set_now(8'hBF, 8'h06, 8'h19, 8'h03, 8'h07, 8'h42, 8'h16);
      @(negedge clk); wr_en = 0; tick = 0;
      chk(pulse, 1'b0, "R10 old byte used");
      tk(8'hBF, 8'h06, 8'h19, 8'h03, 8'h07, 8'h42, 8'h16);
      chk(pulse, 1'b1, "R10 new byte used");

      tag = "R3";
      repeat (4) @(negedge clk);
      chk(pulse, 1'b0, "R3 no tick no pulse");
      @(negedge clk); tick = 1;
      @(negedge clk); chk(pulse, 1'b1, "R3 first");
      @(negedge clk); tick = 0; chk(pulse, 1'b1, "R3 second");
      @(negedge clk); chk(pulse, 1'b0, "R3 one cycle");

      tag = "R5";
      chk(flag, 1'b1, "R5 sticky");
      wr(7, 8'h08);
      chk(flag, 1'b0, "R5 cleared");
      @(negedge clk); wr_en = 1; wr_addr = 3'd7; wr_data = 8'h08; tick = 1;
      @(negedge clk); wr_en = 0; tick = 0;
      chk(flag, 1'b1, "R5 set wins");

      tag = "R6";
      standby = 1;
      wr(7, 8'h00);
      tk(8'hBF, 8'h06, 8'h19, 8'h03, 8'h07, 8'h42, 8'h16);
      chk(pwr_n, 1'b1, "R6 disabled");
      wr(7, 8'h01);
      tk(8'hBF, 8'h06, 8'h19, 8'h03, 8'h07, 8'h42, 8'h16);
      chk(pwr_n, 1'b0, "R6 wake");
      repeat (3) @(negedge clk);
      chk(pwr_n, 1'b0, "R9 held");
      wr(7, 8'h05);
      chk(pwr_n, 1'b1, "R9 released");

      tag = "R7";
      wr(7, 8'h02);
      @(negedge clk); standby = 0;
      tk(8'hBF, 8'h06, 8'h19, 8'h03, 8'h07, 8'h42, 8'h16);
      repeat (4) @(negedge clk);
      chk(pwr_n, 1'b1, "R7 high while absent");
      standby = 1;
      @(negedge clk);
      chk(pwr_n, 1'b0, "R7 wake on return");
      wr(7, 8'h06);

      tag = "R8";
      wr(7, 8'h01);
      @(negedge clk); standby = 0;
      tk(8'hBF, 8'h06, 8'h19, 8'h03, 8'h07, 8'h42, 8'h16);
      repeat (2) @(negedge clk); standby = 1;
      repeat (3) @(negedge clk);
      chk(pwr_n, 1'b1, "R8 no remote no wake");

      tag = "R9";
      wr(7, 8'h02);
      @(negedge clk); standby = 0;
      tk(8'hBF, 8'h06, 8'h19, 8'h03, 8'h07, 8'h42, 8'h16);
      wr(7, 8'h06);
      @(negedge clk); standby = 1;
      repeat (3) @(negedge clk);
      chk(pwr_n, 1'b1, "R9 pending discarded");
      wr(7, 8'h01);
      @(negedge clk); wr_en = 1; wr_addr = 3'd7; wr_data = 8'h05; tick = 1;
      @(negedge clk); wr_en = 0; tick = 0;
      chk(pwr_n, 1'b0, "R9 wake beats release");
      wr(7, 8'h04);

      tag = "R4";  // random mix
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         wr_en = 0; tick = 0;
         case ($urandom_range(0, 4))
            0: begin
               wr_en = 1; wr_addr = 3'($urandom_range(0, 7));
               case ($urandom_range(0, 3))
                  0: wr_data = 8'hC0;
                  1: wr_data = 8'hBF;
                  2: wr_data = 8'($urandom_range(0, 15));
                  default: wr_data = 8'($urandom_range(0, 2));
               endcase
            end
            1: standby = ~standby;
            default: begin
               tick = 1;
               for (int i = 0; i < NF; i++) now_b[i] = 8'($urandom_range(0, 2));
            end
         endcase
      end
      @(negedge clk); wr_en = 0; tick = 0;
      repeat (3) @(negedge clk);
      fin();
   end
endmodule